// File: doc/BRIEF.md
# MSI Doorbell Capture and Interrupt Controller

This block catches message-signalled interrupts that arrive as memory writes from the link side of a PCIe root port. Software programs a 64-bit doorbell address. The low word carries a receive-enable flag in bit 0, and the high word may be left at zero for a 32-bit doorbell. Each inbound write that hits the doorbell while receive is enabled raises one of 32 pending flags. The low five bits of the write data pick which flag.

Software reads the pending word to find the vectors to service, then clears them by writing ones. A per-vector enable word masks which pending flags may raise the interrupt. Legacy wire interrupts share the same output through a separate pending input. When the output is high and the pending word reads zero, the cause was not a message.

Top module: `msi_irq_ctrl`

## Requirements
- R1: After reset, all four CSRs read zero and irq_o is 0. The CSR select codes are 0 = doorbell low, 1 = doorbell high, 2 = vector enable and 3 = pending.
- R2: A CPU write to select 0, 1 or 2 stores the full 32-bit word. A read with the same select returns it on csr_rdata_o, combinationally from the stored value.
- R3: An inbound write with msi_valid_i high, receive enabled and msi_addr_i equal to {doorbell high, doorbell low with bit 0 forced to 0} sets the selected pending bit at that clock edge.
- R4: An inbound write is ignored if its 64-bit address differs in any bit from the compare address. This includes the upper word and address bit 0.
- R5: While bit 0 of the doorbell low register is 0, inbound writes change no pending bit.
- R6: Only msi_data_i[4:0] selects the vector. Higher data bits are ignored.
- R7: A CPU write to select 3 clears every pending bit where the write data holds a 1 and leaves bits with a 0 unchanged.
- R8: If an inbound write sets a bit in the same cycle that a CPU write clears it, the bit ends up set.
- R9: irq_o is a register loaded each cycle with (OR of pending AND enable) OR intx_i. It changes one clock edge after its inputs change.
- R10: A pending bit is recorded even when its enable bit is 0, but such a bit does not raise irq_o.
- R11: No CPU write can set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CPU register write strobe |
| csr_sel_i | input | 2 | CPU register select |
| csr_wdata_i | input | 32 | CPU write data |
| csr_rdata_o | output | 32 | CPU read data for the selected register |
| msi_valid_i | input | 1 | Inbound memory write valid |
| msi_addr_i | input | 64 | Inbound write address |
| msi_data_i | input | 32 | Inbound write data (vector index) |
| intx_i | input | 1 | Legacy interrupt pending |
| irq_o | output | 1 | Shared interrupt output |

## Verification
Several addresses are sent that nearly match the doorbell: one differs only in the upper word, one in bit 2, and one carries bit 0 set. A decoder that compared only the low word, or that let the enable bit leak into the compare, would record a spurious flag. Data with high bits set, such as 0x25 and 0xFFFFFFE3, would light the wrong vector or none at all if the decoder did not truncate to five bits. A write-1-to-clear that lands in the same cycle as an inbound write to the same bit catches a design that lets the clear win, because the event would vanish. Enable masking, intx_i pass-through and the one-cycle irq_o delay are each sampled in the exact cycle, so an unregistered or unmasked output shows up as a mismatch.

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;
  localparam int unsigned CSR_DW = 32;

  typedef enum logic [1:0] {
    SEL_DB_LO   = 2'd0,
    SEL_DB_HI   = 2'd1,
    SEL_VEC_EN  = 2'd2,
    SEL_PENDING = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/msi_csr.sv
module msi_csr
  import msi_irq_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [1:0]            sel_i,
  input  logic [CSR_DW-1:0]     wdata_i,
  output logic [CSR_DW-1:0]     rdata_o,
  input  logic [NUM_VEC-1:0]    pend_i,
  output logic [2*CSR_DW-1:0]   db_addr_o,
  output logic                  rx_en_o,
  output logic [NUM_VEC-1:0]    vec_en_o,
  output logic [NUM_VEC-1:0]    clr_o
);
  logic [CSR_DW-1:0]  db_lo_q, db_hi_q;
  logic [NUM_VEC-1:0] vec_en_q;
  csr_sel_e           sel;

  assign sel = csr_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_lo_q  <= '0;
      db_hi_q  <= '0;
      vec_en_q <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_DB_LO:  db_lo_q  <= wdata_i;
        SEL_DB_HI:  db_hi_q  <= wdata_i;
        SEL_VEC_EN: vec_en_q <= wdata_i[NUM_VEC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_DB_LO:   rdata_o = db_lo_q;
      SEL_DB_HI:   rdata_o = db_hi_q;
      SEL_VEC_EN:  rdata_o[NUM_VEC-1:0] = vec_en_q;
      SEL_PENDING: rdata_o[NUM_VEC-1:0] = pend_i;
      default: ;
    endcase
  end

  // enable bit is not part of the compared address
  assign db_addr_o = {db_hi_q, db_lo_q[CSR_DW-1:1], 1'b0};
  assign rx_en_o   = db_lo_q[0];
  assign vec_en_o  = vec_en_q;
  assign clr_o     = (we_i && sel == SEL_PENDING) ? wdata_i[NUM_VEC-1:0] : '0;
endmodule

// File: rtl/msi_decode.sv
module msi_decode
  import msi_irq_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned ADDR_W  = 64
) (
  input  logic               valid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CSR_DW-1:0]  data_i,
  input  logic [ADDR_W-1:0]  db_addr_i,
  input  logic               rx_en_i,
  output logic [NUM_VEC-1:0] set_oh_o
);
  localparam int unsigned VEC_W = $clog2(NUM_VEC);

  logic             hit;
  logic [VEC_W-1:0] idx;
  logic             unused_data;

  assign hit         = valid_i && rx_en_i && (addr_i == db_addr_i);
  assign idx         = data_i[VEC_W-1:0];
  assign unused_data = ^data_i[CSR_DW-1:VEC_W];

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_dec
    assign set_oh_o[i] = hit && (idx == VEC_W'(i));
  end
endmodule

// File: rtl/msi_pending.sv
module msi_pending #(
  parameter int unsigned NUM_VEC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] pend_o
);
  logic [NUM_VEC-1:0] pend_q;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[i] <= 1'b0;
      else if (set_i[i]) pend_q[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) pend_q[i] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  assert_no_stray_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msi_irq_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned ADDR_W  = 2 * CSR_DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_we_i,
  input  logic [1:0]        csr_sel_i,
  input  logic [CSR_DW-1:0] csr_wdata_i,
  output logic [CSR_DW-1:0] csr_rdata_o,
  input  logic              msi_valid_i,
  input  logic [ADDR_W-1:0] msi_addr_i,
  input  logic [CSR_DW-1:0] msi_data_i,
  input  logic              intx_i,
  output logic              irq_o
);
  logic [ADDR_W-1:0]  db_addr;
  logic               rx_en;
  logic [NUM_VEC-1:0] vec_en, clr, set_oh, pend;
  logic               irq_q;

  msi_csr #(.NUM_VEC(NUM_VEC)) u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (csr_we_i),
    .sel_i    (csr_sel_i),
    .wdata_i  (csr_wdata_i),
    .rdata_o  (csr_rdata_o),
    .pend_i   (pend),
    .db_addr_o(db_addr),
    .rx_en_o  (rx_en),
    .vec_en_o (vec_en),
    .clr_o    (clr)
  );

  msi_decode #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_dec (
    .valid_i  (msi_valid_i),
    .addr_i   (msi_addr_i),
    .data_i   (msi_data_i),
    .db_addr_i(db_addr),
    .rx_en_i  (rx_en),
    .set_oh_o (set_oh)
  );

  msi_pending #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_oh),
    .clr_i (clr),
    .pend_o(pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|(pend & vec_en)) | intx_i;
  end

  assign irq_o = irq_q;

  assert_onehot_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_oh));

  assert_rx_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |-> (set_oh == '0));

  assert_intx_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intx_i |=> irq_o);

  assert_idle_no_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!intx_i && ((pend & vec_en) == '0)) |=> !irq_o);
endmodule

// File: tb/msi_irq_ctrl_bench.sv
module msi_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = 2'd3;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        msi_valid = 1'b0;
  logic [63:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        intx = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5ns clk = ~clk;

  msi_irq_ctrl u_msi_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_we_i(csr_we), .csr_sel_i(csr_sel), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata),
    .msi_valid_i(msi_valid), .msi_addr_i(msi_addr), .msi_data_i(msi_data),
    .intx_i(intx), .irq_o(irq)
  );

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
    logic [31:0] exp_pend;
  } vec_t;

  localparam logic [63:0] DB = 64'h0000_0001_8000_1000;

  localparam vec_t VECS [8] = '{
    '{DB,                       32'h0000_0003, 32'h0000_0008},  // R3
    '{DB,                       32'h0000_0025, 32'h0000_0028},  // R6
    '{64'h0000_0001_8000_1004,  32'h0000_0007, 32'h0000_0028},  // R4
    '{64'h0000_0000_8000_1000,  32'h0000_0009, 32'h0000_0028},  // R4 high word
    '{DB,                       32'h0000_001F, 32'h8000_0028},  // R3
    '{64'h0000_0001_8000_1001,  32'h0000_0001, 32'h8000_0028},  // R4 bit 0
    '{DB,                       32'h0000_0000, 32'h8000_0029},  // R3
    '{DB,                       32'hFFFF_FFE3, 32'h8000_0029}   // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0; csr_sel = 2'd3;
  endtask

  task automatic csr_rd(input logic [1:0] sel, output logic [31:0] d);
    csr_sel = sel;
    #1ns;
    d = csr_rdata;
    csr_sel = 2'd3;
  endtask

  task automatic msi_wr(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = a; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      csr_rd(2'(s), r);
      chk("R1", r, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 readback, receive still disabled
    csr_wr(2'd0, 32'h8000_1000);
    csr_wr(2'd1, 32'h0000_0001);
    csr_rd(2'd0, r); chk("R2 lo", r, 32'h8000_1000);
    csr_rd(2'd1, r); chk("R2 hi", r, 32'h0000_0001);

    // R5 disabled receive
    msi_wr(DB, 32'h2);
    csr_rd(2'd3, r); chk("R5", r, 32'h0);

    csr_wr(2'd0, 32'h8000_1001);
    csr_rd(2'd0, r); chk("R2 lo en", r, 32'h8000_1001);

    // table walk, enable word still zero
    for (int i = 0; i < 8; i++) begin
      msi_wr(VECS[i].addr, VECS[i].data);
      csr_rd(2'd3, r);
      chk($sformatf("R3/R4/R6 vec%0d", i), r, VECS[i].exp_pend);
    end

    // R10 pending but masked
    @(negedge clk);
    chk("R10 masked irq", {31'h0, irq}, 32'h0);

    // R9 timing after enabling
    csr_wr(2'd2, 32'hFFFF_FFFF);
    csr_rd(2'd2, r); chk("R2 en", r, 32'hFFFF_FFFF);
    chk("R9 delay", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq up", {31'h0, irq}, 32'h1);

    // R7 / R11 write-1-to-clear
    csr_wr(2'd3, 32'h0000_0021);
    csr_rd(2'd3, r); chk("R7", r, 32'h8000_0008);
    csr_wr(2'd3, 32'h0000_0000);
    csr_rd(2'd3, r); chk("R11", r, 32'h8000_0008);
    csr_wr(2'd3, 32'hFFFF_FFFF);
    csr_rd(2'd3, r); chk("R7 all", r, 32'h0);
    chk("R9 hold", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq down", {31'h0, irq}, 32'h0);

    // R8 set beats clear
    msi_wr(DB, 32'd8);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = 2'd3; csr_wdata = 32'h0000_0110;
    msi_valid = 1'b1; msi_addr = DB; msi_data = 32'd4;
    @(negedge clk);
    csr_we = 1'b0; msi_valid = 1'b0;
    csr_rd(2'd3, r); chk("R8", r, 32'h0000_0010);

    // R10 per-vector mask
    csr_wr(2'd2, 32'hFFFF_FFEF);
    @(negedge clk);
    chk("R10 mask bit4", {31'h0, irq}, 32'h0);

    // R9 intx pass-through
    intx = 1'b1;
    @(negedge clk);
    chk("R9 intx", {31'h0, irq}, 32'h1);
    csr_rd(2'd3, r); chk("R9 intx pend", r, 32'h0000_0010);
    intx = 1'b0;
    @(negedge clk);
    chk("R9 intx off", {31'h0, irq}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule